// File: doc/BRIEF.md
# ROM-Driven Instruction Decoder

This block turns one 32-bit instruction word of a 64-bit RISC-V integer core into the control information that a single-cycle data path needs. Thirty-two pattern detectors compare the word at the same time. Each detector looks at the opcode, and at funct3 and funct7 (or funct6 for the 64-bit shifts) where the format has them, and raises one match bit. A priority encoder reduces the match vector to an instruction number. That number addresses a constant table with one packed control word per instruction.

The register index fields are cut straight from their fixed positions. The all-zero word is reserved as "unimplemented" and marks the end of a program. That word, and any word that no detector recognises, selects the last table row. This row raises the halt output and disables every write. The block is purely combinational, so the core uses its outputs in the same cycle that the word is presented. Immediate generation, the ALU and the register file are outside the block.

Top module: `rom_insn_decoder`

## Requirements
- R1: rs1_o equals instr_i[19:15], rs2_o equals instr_i[24:20] and rd_o equals instr_i[11:7] for every instruction word, whether it is recognised or not.
- R2: The following fields identify the instructions: opcode instr_i[6:0], funct3 instr_i[14:12], funct7 instr_i[31:25], and funct6 instr_i[31:26] for immediate shifts. Each supported instruction yields inum_o as follows: NOP 0, ADD 1, SUB 2, SLL 3, SLT 4, XOR 5, SRL 6, SRA 7, OR 8, AND 9, ADDI 10, SLTI 11, XORI 12, ORI 13, ANDI 14, SLLI 15, SRLI 16, SRAI 17, LB 18, LW 19, LD 20, SB 21, SW 22, SD 23, BEQ 24, BNE 25, BLT 26, BGE 27, JAL 28, JALR 29, LUI 30. The opcodes are 0110011 (register), 0010011 (immediate), 0000011 (load), 0100011 (store), 1100011 (branch), 1101111 (JAL), 1100111 (JALR) and 0110111 (LUI). The funct7/funct6 value selects between the alternate forms SUB/SRA/SRAI and the normal forms.
- R3: When more than one detector matches, the lowest instruction number wins. The word 0x00000013 matches both NOP and ADDI and must give inum_o 0 with register write disabled.
- R4: The all-zero word, and every word that matches no supported pattern, gives inum_o 31.
- R5: halt_o is 1 exactly when inum_o is 31. In that row every other control field is 0, so there is no register write and no memory write.
- R6: ctl_o is laid out as follows: bit 17 halt, [16:15] write-back select (0 ALU, 1 memory, 2 PC+4), [14:13] branch condition (0 eq, 1 ne, 2 lt, 3 ge), [12:11] PC select (0 PC+4, 1 conditional branch, 2 jump), [10:9] memory size (0 byte, 2 word, 3 double-word), bit 8 memory read, bit 7 memory write, bit 6 ALU B from immediate, bit 5 ALU A from PC, bit 4 register write, [3:0] ALU operation (0 add, 1 sub, 2 sll, 3 slt, 4 xor, 5 srl, 6 sra, 7 or, 8 and, 9 pass B). Register and immediate ALU instructions set register write and the matching ALU operation. Immediate forms also set ALU B from immediate. NOP has only ALU B from immediate set.
- R7: Loads set register write, B immediate, memory read, write-back memory and their size. Stores set B immediate, memory write and their size, with no register write. Branches select sub, PC select 1 and their condition, with no register write. JAL sets register write, A from PC, B immediate, PC select 2 and write-back PC+4. JALR has the same fields as JAL except A from PC. LUI sets register write, B immediate and pass B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word to decode |
| rs1_o | output | 5 | First source register index |
| rs2_o | output | 5 | Second source register index |
| rd_o | output | 5 | Destination register index |
| inum_o | output | 5 | Priority-encoded instruction number (table address) |
| ctl_o | output | 18 | Packed control word read from the table |
| halt_o | output | 1 | End-of-program flag (unimplemented or unknown word) |

## Verification
No register lies on any path from instr_i to the outputs. Every result, including the register indices, the instruction number, the control word and the halt flag, is therefore due in the same cycle that the word is applied. The bench changes instr_i just after a rising edge and reads all outputs at the following falling edge, half a period later. Each check thus sees the settled value for exactly one stimulus, and the next word is not yet applied.

// File: rtl/idec_pkg.sv
package idec_pkg;

    localparam int INSN_W      = 32;
    localparam int REG_IDX_W   = 5;
    localparam int NUM_ENTRIES = 32;
    localparam int INUM_W      = $clog2(NUM_ENTRIES);
    localparam int NOP_IDX     = 0;
    localparam int UNIMP_IDX   = NUM_ENTRIES - 1;

    localparam logic [6:0] OP_REG    = 7'b0110011;
    localparam logic [6:0] OP_IMM    = 7'b0010011;
    localparam logic [6:0] OP_LOAD   = 7'b0000011;
    localparam logic [6:0] OP_STORE  = 7'b0100011;
    localparam logic [6:0] OP_BRANCH = 7'b1100011;
    localparam logic [6:0] OP_JAL    = 7'b1101111;
    localparam logic [6:0] OP_JALR   = 7'b1100111;
    localparam logic [6:0] OP_LUI    = 7'b0110111;

    localparam logic [6:0] F7_BASE = 7'b0000000;
    localparam logic [6:0] F7_ALT  = 7'b0100000;

    typedef enum logic [3:0] {
        ALU_ADD   = 4'd0,
        ALU_SUB   = 4'd1,
        ALU_SLL   = 4'd2,
        ALU_SLT   = 4'd3,
        ALU_XOR   = 4'd4,
        ALU_SRL   = 4'd5,
        ALU_SRA   = 4'd6,
        ALU_OR    = 4'd7,
        ALU_AND   = 4'd8,
        ALU_PASSB = 4'd9
    } alu_op_e;

    typedef struct packed {
        logic       halt;
        logic [1:0] wb_sel;
        logic [1:0] br_cond;
        logic [1:0] pc_sel;
        logic [1:0] mem_size;
        logic       mem_re;
        logic       mem_we;
        logic       b_imm;
        logic       a_pc;
        logic       reg_we;
        alu_op_e    alu_op;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    function automatic logic [INSN_W-1:0] fld(input logic [6:0] f7,
                                              input logic [2:0] f3,
                                              input logic [6:0] op);
        return {f7, 10'b0, f3, 5'b0, op};
    endfunction

    // Which bits each detector compares
    function automatic logic [INSN_W-1:0] pat_mask(input int k);
        if (k == NOP_IDX || k == UNIMP_IDX) return 32'hFFFF_FFFF;
        if (k >= 1 && k <= 9)               return 32'hFE00_707F;
        if (k >= 15 && k <= 17)             return 32'hFC00_707F;
        if (k == 28 || k == 30)             return 32'h0000_007F;
        return 32'h0000_707F;
    endfunction

    // Value the masked bits must equal; detector order equals row order
    function automatic logic [INSN_W-1:0] pat_value(input int k);
        case (k)
            0:  return 32'h0000_0013;
            1:  return fld(F7_BASE, 3'd0, OP_REG);
            2:  return fld(F7_ALT,  3'd0, OP_REG);
            3:  return fld(F7_BASE, 3'd1, OP_REG);
            4:  return fld(F7_BASE, 3'd2, OP_REG);
            5:  return fld(F7_BASE, 3'd4, OP_REG);
            6:  return fld(F7_BASE, 3'd5, OP_REG);
            7:  return fld(F7_ALT,  3'd5, OP_REG);
            8:  return fld(F7_BASE, 3'd6, OP_REG);
            9:  return fld(F7_BASE, 3'd7, OP_REG);
            10: return fld(F7_BASE, 3'd0, OP_IMM);
            11: return fld(F7_BASE, 3'd2, OP_IMM);
            12: return fld(F7_BASE, 3'd4, OP_IMM);
            13: return fld(F7_BASE, 3'd6, OP_IMM);
            14: return fld(F7_BASE, 3'd7, OP_IMM);
            15: return fld(F7_BASE, 3'd1, OP_IMM);
            16: return fld(F7_BASE, 3'd5, OP_IMM);
            17: return fld(F7_ALT,  3'd5, OP_IMM);
            18: return fld(F7_BASE, 3'd0, OP_LOAD);
            19: return fld(F7_BASE, 3'd2, OP_LOAD);
            20: return fld(F7_BASE, 3'd3, OP_LOAD);
            21: return fld(F7_BASE, 3'd0, OP_STORE);
            22: return fld(F7_BASE, 3'd2, OP_STORE);
            23: return fld(F7_BASE, 3'd3, OP_STORE);
            24: return fld(F7_BASE, 3'd0, OP_BRANCH);
            25: return fld(F7_BASE, 3'd1, OP_BRANCH);
            26: return fld(F7_BASE, 3'd4, OP_BRANCH);
            27: return fld(F7_BASE, 3'd5, OP_BRANCH);
            28: return fld(F7_BASE, 3'd0, OP_JAL);
            29: return fld(F7_BASE, 3'd0, OP_JALR);
            30: return fld(F7_BASE, 3'd0, OP_LUI);
            default: return 32'h0000_0000;
        endcase
    endfunction

    function automatic alu_op_e alu_of(input int k);
        case (k)
            1, 10, 18, 19, 20, 21, 22, 23, 28, 29: return ALU_ADD;
            2, 24, 25, 26, 27:                     return ALU_SUB;
            3, 15:                                 return ALU_SLL;
            4, 11:                                 return ALU_SLT;
            5, 12:                                 return ALU_XOR;
            6, 16:                                 return ALU_SRL;
            7, 17:                                 return ALU_SRA;
            8, 13:                                 return ALU_OR;
            9, 14:                                 return ALU_AND;
            30:                                    return ALU_PASSB;
            default:                               return ALU_ADD;
        endcase
    endfunction

    function automatic logic [1:0] size_of(input int k);
        case (k)
            18, 21:  return 2'd0;
            19, 22:  return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    function automatic ctl_t rom_row(input int k);
        ctl_t c;
        c = '0;
        c.alu_op = alu_of(k);
        if (k == UNIMP_IDX) begin
            c.halt = 1'b1;
        end else if (k == NOP_IDX) begin
            c.b_imm = 1'b1;
        end else if (k <= 9) begin
            c.reg_we = 1'b1;
        end else if (k <= 17) begin
            c.reg_we = 1'b1;
            c.b_imm  = 1'b1;
        end else if (k <= 20) begin
            c.reg_we   = 1'b1;
            c.b_imm    = 1'b1;
            c.mem_re   = 1'b1;
            c.wb_sel   = 2'd1;
            c.mem_size = size_of(k);
        end else if (k <= 23) begin
            c.b_imm    = 1'b1;
            c.mem_we   = 1'b1;
            c.mem_size = size_of(k);
        end else if (k <= 27) begin
            c.pc_sel  = 2'd1;
            c.br_cond = 2'(k - 24);
        end else if (k <= 29) begin
            c.reg_we = 1'b1;
            c.b_imm  = 1'b1;
            c.a_pc   = (k == 28);
            c.pc_sel = 2'd2;
            c.wb_sel = 2'd2;
        end else begin
            c.reg_we = 1'b1;
            c.b_imm  = 1'b1;
        end
        return c;
    endfunction

endpackage

// File: rtl/idec_match_bank.sv
module idec_match_bank
    import idec_pkg::*;
#(
    parameter int N = NUM_ENTRIES
) (
    input  logic [INSN_W-1:0] insn,
    output logic [N-1:0]      hit
);

    for (genvar g = 0; g < N; g++) begin : g_det
        localparam logic [INSN_W-1:0] MASK = pat_mask(g);
        localparam logic [INSN_W-1:0] VAL  = pat_value(g);
        assign hit[g] = ((insn & MASK) == VAL);
    end

endmodule

// File: rtl/idec_prio.sv
module idec_prio #(
    parameter int N           = 32,
    parameter int W           = $clog2(N),
    parameter int DEFAULT_IDX = N - 1
) (
    input  logic [N-1:0] hit,
    output logic [W-1:0] idx
);

    // Scan from the top so that the lowest set input is written last
    always_comb begin
        idx = W'(DEFAULT_IDX);
        for (int i = N - 1; i >= 0; i--) begin
            if (hit[i]) idx = W'(i);
        end
    end

endmodule

// File: rtl/idec_rom.sv
module idec_rom
    import idec_pkg::*;
#(
    parameter int N = NUM_ENTRIES,
    parameter int W = $clog2(N)
) (
    input  logic [W-1:0] addr,
    output ctl_t         row
);

    ctl_t table_q [N];

    for (genvar g = 0; g < N; g++) begin : g_row
        assign table_q[g] = rom_row(g);
    end

    assign row = table_q[addr];

endmodule

// File: rtl/idec_fields.sv
module idec_fields
    import idec_pkg::*;
(
    input  logic [24:15]          src_bits,
    input  logic [11:7]           dst_bits,
    output logic [REG_IDX_W-1:0]  rs1,
    output logic [REG_IDX_W-1:0]  rs2,
    output logic [REG_IDX_W-1:0]  rd
);

    assign rs1 = src_bits[19:15];
    assign rs2 = src_bits[24:20];
    assign rd  = dst_bits;

endmodule

// File: rtl/rom_insn_decoder.sv
module rom_insn_decoder
    import idec_pkg::*;
(
    input  logic [INSN_W-1:0]    instr_i,
    output logic [REG_IDX_W-1:0] rs1_o,
    output logic [REG_IDX_W-1:0] rs2_o,
    output logic [REG_IDX_W-1:0] rd_o,
    output logic [INUM_W-1:0]    inum_o,
    output logic [CTL_W-1:0]     ctl_o,
    output logic                 halt_o
);

    logic [NUM_ENTRIES-1:0] hit;
    ctl_t                   row;

    idec_fields u_fields (
        .src_bits (instr_i[24:15]),
        .dst_bits (instr_i[11:7]),
        .rs1      (rs1_o),
        .rs2      (rs2_o),
        .rd       (rd_o)
    );

    idec_match_bank #(.N(NUM_ENTRIES)) u_match (
        .insn (instr_i),
        .hit  (hit)
    );

    idec_prio #(
        .N           (NUM_ENTRIES),
        .W           (INUM_W),
        .DEFAULT_IDX (UNIMP_IDX)
    ) u_prio (
        .hit (hit),
        .idx (inum_o)
    );

    idec_rom #(.N(NUM_ENTRIES), .W(INUM_W)) u_rom (
        .addr (inum_o),
        .row  (row)
    );

    assign ctl_o  = row;
    assign halt_o = row.halt;

endmodule

// File: rtl/rom_insn_decoder_chk.sv
module rom_insn_decoder_chk
    import idec_pkg::*;
(
    input logic [INSN_W-1:0] instr,
    input logic [INUM_W-1:0] inum,
    input logic              halt,
    input logic              reg_we,
    input logic              mem_we
);

    always_comb begin
        // R5
        halt_matches_unimp_chk: assert (halt == (inum == INUM_W'(UNIMP_IDX)));
        // R4
        zero_word_unimp_chk: assert (instr != '0 || inum == INUM_W'(UNIMP_IDX));
        // R5
        unimp_no_write_chk: assert (inum != INUM_W'(UNIMP_IDX) || (!reg_we && !mem_we));
        // R3
        nop_wins_chk: assert (instr != 32'h0000_0013 || (inum == INUM_W'(NOP_IDX) && !reg_we));
        // R7
        store_no_regwrite_chk: assert (!mem_we || !reg_we);
    end

endmodule

bind rom_insn_decoder rom_insn_decoder_chk u_chk (
    .instr  (instr_i),
    .inum   (inum_o),
    .halt   (halt_o),
    .reg_we (ctl_o[4]),
    .mem_we (ctl_o[7])
);

// File: tb/rom_insn_decoder_tb.sv
module rom_insn_decoder_tb;

    localparam int CLK_NS = 8;

    logic        clk = 1'b0;
    logic [31:0] instr;
    logic [4:0]  rs1, rs2, rd, inum;
    logic [17:0] ctl;
    logic        halt;
    int          n_tests = 0;
    int          n_fail  = 0;
    bit          done    = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    rom_insn_decoder u_dut (
        .instr_i (instr),
        .rs1_o   (rs1),
        .rs2_o   (rs2),
        .rd_o    (rd),
        .inum_o  (inum),
        .ctl_o   (ctl),
        .halt_o  (halt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s word=%h actual=%h expected=%h", req, instr, act, exp);
        end
    endtask

    // Reference decode written from the requirement table
    function automatic int ref_inum(input logic [31:0] w);
        logic [6:0] op, f7;
        logic [2:0] f3;
        op = w[6:0]; f3 = w[14:12]; f7 = w[31:25];
        case (op)
            7'b0110011: begin
                if (f7 == 7'h00) begin
                    case (f3)
                        3'd0: return 1; 3'd1: return 3; 3'd2: return 4; 3'd4: return 5;
                        3'd5: return 6; 3'd6: return 8; 3'd7: return 9; default: return 31;
                    endcase
                end else if (f7 == 7'h20) begin
                    if (f3 == 3'd0) return 2;
                    if (f3 == 3'd5) return 7;
                end
                return 31;
            end
            7'b0010011: begin
                if (w == 32'h13) return 0;
                case (f3)
                    3'd0: return 10; 3'd2: return 11; 3'd4: return 12;
                    3'd6: return 13; 3'd7: return 14;
                    3'd1: return (w[31:26] == 6'd0) ? 15 : 31;
                    3'd5: begin
                        if (w[31:26] == 6'd0)        return 16;
                        if (w[31:26] == 6'b010000)   return 17;
                        return 31;
                    end
                    default: return 31;
                endcase
            end
            7'b0000011: return (f3 == 0) ? 18 : (f3 == 2) ? 19 : (f3 == 3) ? 20 : 31;
            7'b0100011: return (f3 == 0) ? 21 : (f3 == 2) ? 22 : (f3 == 3) ? 23 : 31;
            7'b1100011: return (f3 == 0) ? 24 : (f3 == 1) ? 25 : (f3 == 4) ? 26 :
                               (f3 == 5) ? 27 : 31;
            7'b1101111: return 28;
            7'b1100111: return (f3 == 0) ? 29 : 31;
            7'b0110111: return 30;
            default:    return 31;
        endcase
    endfunction

    function automatic logic [17:0] exp_ctl(input int k);
        logic h, re, we, bi, ap, rw;
        logic [1:0] wb, br, pc, sz;
        logic [3:0] op;
        {h, re, we, bi, ap, rw} = '0;
        {wb, br, pc, sz} = '0;
        op = 4'd0;
        if (k == 31) h = 1'b1;
        else if (k == 0) bi = 1'b1;
        else if (k <= 9) begin rw = 1'b1; op = 4'(k - 1); end
        else if (k <= 17) begin
            rw = 1'b1; bi = 1'b1;
            case (k)
                10: op = 4'd0; 11: op = 4'd3; 12: op = 4'd4; 13: op = 4'd7;
                14: op = 4'd8; 15: op = 4'd2; 16: op = 4'd5; default: op = 4'd6;
            endcase
        end else if (k <= 20) begin
            rw = 1'b1; bi = 1'b1; re = 1'b1; wb = 2'd1;
            sz = (k == 18) ? 2'd0 : (k == 19) ? 2'd2 : 2'd3;
        end else if (k <= 23) begin
            bi = 1'b1; we = 1'b1;
            sz = (k == 21) ? 2'd0 : (k == 22) ? 2'd2 : 2'd3;
        end else if (k <= 27) begin
            op = 4'd1; pc = 2'd1; br = 2'(k - 24);
        end else if (k <= 29) begin
            rw = 1'b1; bi = 1'b1; ap = (k == 28); pc = 2'd2; wb = 2'd2;
        end else begin
            rw = 1'b1; bi = 1'b1; op = 4'd9;
        end
        return {h, wb, br, pc, sz, re, we, bi, ap, rw, op};
    endfunction

    // Directed word for each supported instruction, register bits from r
    function automatic logic [31:0] dir_word(input int k, input logic [31:0] r);
        logic [31:0] b;
        b = r;
        case (k)
            1:  b = {7'h00, r[24:15], 3'd0, r[11:7], 7'b0110011};
            2:  b = {7'h20, r[24:15], 3'd0, r[11:7], 7'b0110011};
            3:  b = {7'h00, r[24:15], 3'd1, r[11:7], 7'b0110011};
            4:  b = {7'h00, r[24:15], 3'd2, r[11:7], 7'b0110011};
            5:  b = {7'h00, r[24:15], 3'd4, r[11:7], 7'b0110011};
            6:  b = {7'h00, r[24:15], 3'd5, r[11:7], 7'b0110011};
            7:  b = {7'h20, r[24:15], 3'd5, r[11:7], 7'b0110011};
            8:  b = {7'h00, r[24:15], 3'd6, r[11:7], 7'b0110011};
            9:  b = {7'h00, r[24:15], 3'd7, r[11:7], 7'b0110011};
            10: b = {r[31:15], 3'd0, r[11:7], 7'b0010011};
            11: b = {r[31:15], 3'd2, r[11:7], 7'b0010011};
            12: b = {r[31:15], 3'd4, r[11:7], 7'b0010011};
            13: b = {r[31:15], 3'd6, r[11:7], 7'b0010011};
            14: b = {r[31:15], 3'd7, r[11:7], 7'b0010011};
            15: b = {6'd0, r[25:15], 3'd1, r[11:7], 7'b0010011};
            16: b = {6'd0, r[25:15], 3'd5, r[11:7], 7'b0010011};
            17: b = {6'b010000, r[25:15], 3'd5, r[11:7], 7'b0010011};
            18: b = {r[31:15], 3'd0, r[11:7], 7'b0000011};
            19: b = {r[31:15], 3'd2, r[11:7], 7'b0000011};
            20: b = {r[31:15], 3'd3, r[11:7], 7'b0000011};
            21: b = {r[31:15], 3'd0, r[11:7], 7'b0100011};
            22: b = {r[31:15], 3'd2, r[11:7], 7'b0100011};
            23: b = {r[31:15], 3'd3, r[11:7], 7'b0100011};
            24: b = {r[31:15], 3'd0, r[11:7], 7'b1100011};
            25: b = {r[31:15], 3'd1, r[11:7], 7'b1100011};
            26: b = {r[31:15], 3'd4, r[11:7], 7'b1100011};
            27: b = {r[31:15], 3'd5, r[11:7], 7'b1100011};
            28: b = {r[31:7], 7'b1101111};
            29: b = {r[31:15], 3'd0, r[11:7], 7'b1100111};
            30: b = {r[31:7], 7'b0110111};
            0:  b = 32'h0000_0013;
            default: b = 32'h0000_0000;
        endcase
        return b;
    endfunction

    function automatic logic [6:0] pick_op(input int s);
        case (s)
            0: return 7'b0110011; 1: return 7'b0010011; 2: return 7'b0000011;
            3: return 7'b0100011; 4: return 7'b1100011; 5: return 7'b1101111;
            6: return 7'b1100111; default: return 7'b0110111;
        endcase
    endfunction

    task automatic apply_and_check(input logic [31:0] w);
        int k;
        @(posedge clk);
        instr = w;
        @(negedge clk);
        k = ref_inum(w);
        chk("R1 rs1", 32'(rs1), 32'(w[19:15]));
        chk("R1 rs2", 32'(rs2), 32'(w[24:20]));
        chk("R1 rd",  32'(rd),  32'(w[11:7]));
        chk((k == 31) ? "R4 inum" : (k == 0) ? "R3 inum" : "R2 inum", 32'(inum), 32'(k));
        chk((k >= 18 && k <= 30) ? "R7 ctl" : "R6 ctl", 32'(ctl), 32'(exp_ctl(k)));
        chk("R5 halt", 32'(halt), 32'(k == 31));
    endtask

    initial begin
        logic [31:0] w;
        int s;
        void'($urandom(32'd20260416));
        instr = 32'h0;
        // R4 R5: reserved all-zero word
        apply_and_check(32'h0000_0000);
        // R3: NOP overlaps ADDI, lower number wins
        apply_and_check(32'h0000_0013);
        apply_and_check(32'h0000_0093);
        // R2 R6 R7: every supported instruction, twice with fresh register bits
        for (int rep = 0; rep < 2; rep++) begin
            for (int k = 0; k < 31; k++) apply_and_check(dir_word(k, $urandom));
        end
        // R4: near misses
        apply_and_check({7'h20, 10'h3FF, 3'd1, 5'd3, 7'b0110011});
        apply_and_check({6'b010000, 11'h7FF, 3'd1, 5'd3, 7'b0010011});
        apply_and_check({17'h1ABCD, 3'd3, 5'd9, 7'b0010011});
        apply_and_check({17'h1ABCD, 3'd7, 5'd9, 7'b0000011});
        apply_and_check({17'h1ABCD, 3'd2, 5'd9, 7'b1100011});
        apply_and_check({17'h1ABCD, 3'd1, 5'd9, 7'b1100111});
        apply_and_check(32'hFFFF_FFFF);
        // Constrained random mix
        for (int i = 0; i < 400; i++) begin
            w = $urandom;
            s = int'($urandom % 9);
            if (s < 8) w[6:0] = pick_op(s);
            if ($urandom % 2 == 0) w[31:25] = ($urandom % 2 == 0) ? 7'h00 : 7'h20;
            apply_and_check(w);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R2 watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule